// File: doc/BRIEF.md
# Glitch-Free Two-Input Clock Switch

This block picks one of two clock inputs, which may have no phase or frequency relation to each other, and passes it to a single clock output without producing shortened high or low pulses. Each input has a pair of controls, a select line and an enable line. An input is requested only when both of its lines are high. When the request moves from one input to the other, the switch first waits for the edge that ends the active phase of the clock that is driving the output. It then holds the output at an idle level. It hands over to the new clock only on the matching edge of that clock.

A compile-time parameter picks the polarity. In the default mode the switch acts on falling edges and idles low. In the other mode it acts on rising edges and idles high. A second parameter picks which input drives the output during and after reset. Each input also has an override line. While it is set, the output leaves that input the moment its request drops, without waiting for a clock edge. Dropping an enable line is also a fast path that leaves at once, so a switch made only with the enable lines is not held back by the old clock.

Top module: `clk_glitchless_mux`

## Requirements
- R1: An input is requested only when its select and its enable lines are both high. An input whose select is high and whose enable is low never drives the output.
- R2: With PARK_HIGH=0, after a select change the output keeps following the old clock until that clock's next falling edge. It then stays low until the new clock has made a falling edge, and after that it follows the new clock.
- R3: With PARK_HIGH=1 the behaviour is mirrored. The switch releases the old clock on its rising edge, holds the output high, and takes the new clock on a rising edge.
- R4: While an input's override line is high, dropping that input's request removes it from the output at once, even in the middle of its high phase. Setting the override line on an input that stays requested has no effect on the output.
- R5: While rst_ni is low, the input chosen by PRESELECT (0 for input 0, 1 for input 1) drives the output, provided that its enable is high.
- R6: When neither input is requested, the output holds the idle level: low when PARK_HIGH=0 and high when PARK_HIGH=1.
- R7: When both select lines are held high and the request moves by enable lines only, the old clock is removed from the output at once. The switch does not wait for an edge of the old clock.
- R8: After a select-line change, the output follows the newly requested clock within three periods of the slower input clock.
- R9: When both inputs are requested at once, the output stays at the idle level. The two inputs are never gated onto the output together.
- R10: During select-line switching, no high or low pulse on the output is shorter than the shorter half-period of the two input clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk0_i | input | 1 | Clock input 0 |
| clk1_i | input | 1 | Clock input 1 |
| rst_ni | input | 1 | Asynchronous active-low reset; applies the preselection |
| sel0_i | input | 1 | Select line of input 0 |
| en0_i | input | 1 | Enable line of input 0 |
| ign0_i | input | 1 | Immediate-release override for input 0 |
| sel1_i | input | 1 | Select line of input 1 |
| en1_i | input | 1 | Enable line of input 1 |
| ign1_i | input | 1 | Immediate-release override for input 1 |
| clk_o | output | 1 | Switched clock output |

## Verification
Two functions can act in the same instant. One is releasing the old clock and the other is the fast exit through an override or enable line. The bench provokes this by dropping a request one nanosecond after a rising edge of clock 0, while that clock is still high. With the override set, or with an enable-only switch, it expects the output to be low at once. Without the override, it expects the output to stay high until the falling edge. The pulse-width monitor runs only during select-line switching. The override and enable checks therefore test that these paths really cut the high phase short, and the monitor is not fooled by the short pulses that the bypass is meant to produce.

// File: rtl/clk_switch_pkg.sv
`timescale 1ns/10ps
package clk_switch_pkg;

    // Per-input handshake state, all clocked on that input's park edge.
    typedef struct packed {
        logic sync1;   // first stage: request seen while the other side is released
        logic gate;    // second stage: this input may drive the output
        logic armed;   // set after the first park edge following reset
    } cs_branch_t;

endpackage

// File: rtl/clk_switch_branch.sv
`timescale 1ns/10ps
module clk_switch_branch
    import clk_switch_pkg::*;
#(
    parameter bit PARK_HIGH = 1'b0,
    parameter int IDX       = 0,
    parameter int PRESELECT = 0
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    input  logic req_other_i,
    input  logic en_i,
    input  logic ign_i,
    input  logic other_gate_i,
    output logic gate_o
);

    localparam logic RST_ON = (PRESELECT == IDX);

    logic       park_clk;
    logic       want;
    cs_branch_t st_d;
    cs_branch_t st_q;

    // The park edge is the edge that ends the active phase of the clock.
    generate
        if (PARK_HIGH) begin : g_rise
            assign park_clk = clk_i;
        end else begin : g_fall
            assign park_clk = ~clk_i;
        end
    endgenerate

    always_comb begin
        want        = req_i & ~req_other_i;
        st_d        = st_q;
        st_d.sync1  = want & ~other_gate_i;
        st_d.gate   = st_q.sync1 & want;
        st_d.armed  = 1'b1;
    end

    always_ff @(posedge park_clk or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{sync1: RST_ON, gate: RST_ON, armed: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    // Enable drop and override-with-request-drop release at once.
    assign gate_o = st_q.gate & en_i & (req_i | ~ign_i);

    // R1: an input not wanted at one park edge is released by the next one
    a_r1_unwanted_released: assert property (
        @(posedge park_clk) disable iff (!rst_ni)
        (st_q.armed && $past(!want)) |-> !st_q.gate
    );

    // R9: this side only starts driving once the other side has let go
    a_r9_enter_after_release: assert property (
        @(posedge park_clk) disable iff (!rst_ni)
        (st_q.armed && $rose(st_q.gate)) |-> !other_gate_i
    );

endmodule

// File: rtl/clk_switch_merge.sv
`timescale 1ns/10ps
module clk_switch_merge #(
    parameter bit PARK_HIGH = 1'b0
) (
    input  logic clk_a_i,
    input  logic clk_b_i,
    input  logic gate_a_i,
    input  logic gate_b_i,
    output logic clk_o
);

    generate
        if (PARK_HIGH) begin : g_idle_high
            assign clk_o = (clk_a_i | ~gate_a_i) & (clk_b_i | ~gate_b_i);
        end else begin : g_idle_low
            assign clk_o = (clk_a_i & gate_a_i) | (clk_b_i & gate_b_i);
        end
    endgenerate

endmodule

// File: rtl/clk_glitchless_mux.sv
`timescale 1ns/10ps
module clk_glitchless_mux #(
    parameter bit PARK_HIGH = 1'b0,
    parameter int PRESELECT = 0
) (
    input  logic clk0_i,
    input  logic clk1_i,
    input  logic rst_ni,
    input  logic sel0_i,
    input  logic en0_i,
    input  logic ign0_i,
    input  logic sel1_i,
    input  logic en1_i,
    input  logic ign1_i,
    output logic clk_o
);

    localparam logic IDLE_LEVEL = PARK_HIGH;

    logic req0;
    logic req1;
    logic gate0;
    logic gate1;

    assign req0 = sel0_i & en0_i;
    assign req1 = sel1_i & en1_i;

    clk_switch_branch #(
        .PARK_HIGH (PARK_HIGH),
        .IDX       (0),
        .PRESELECT (PRESELECT)
    ) u_branch0 (
        .clk_i        (clk0_i),
        .rst_ni       (rst_ni),
        .req_i        (req0),
        .req_other_i  (req1),
        .en_i         (en0_i),
        .ign_i        (ign0_i),
        .other_gate_i (gate1),
        .gate_o       (gate0)
    );

    clk_switch_branch #(
        .PARK_HIGH (PARK_HIGH),
        .IDX       (1),
        .PRESELECT (PRESELECT)
    ) u_branch1 (
        .clk_i        (clk1_i),
        .rst_ni       (rst_ni),
        .req_i        (req1),
        .req_other_i  (req0),
        .en_i         (en1_i),
        .ign_i        (ign1_i),
        .other_gate_i (gate0),
        .gate_o       (gate1)
    );

    clk_switch_merge #(
        .PARK_HIGH (PARK_HIGH)
    ) u_merge (
        .clk_a_i  (clk0_i),
        .clk_b_i  (clk1_i),
        .gate_a_i (gate0),
        .gate_b_i (gate1),
        .clk_o    (clk_o)
    );

    // R9: the two inputs are never enabled together
    a_r9_exclusive_on_clk0: assert property (
        @(posedge clk0_i) disable iff (!rst_ni) !(gate0 && gate1)
    );
    a_r9_exclusive_on_clk1: assert property (
        @(posedge clk1_i) disable iff (!rst_ni) !(gate0 && gate1)
    );

    // R6: with both branches released the output sits at the idle level
    a_r6_idle_level: assert property (
        @(posedge clk1_i) disable iff (!rst_ni)
        (!gate0 && !gate1) |-> (clk_o == IDLE_LEVEL)
    );

endmodule

// File: tb/clk_glitchless_mux_tb.sv
`timescale 1ns/10ps
module clk_glitchless_mux_tb;

    logic tb_clk = 1'b0;
    logic clk0   = 1'b0;
    logic clk1   = 1'b0;
    logic rst_n  = 1'b0;
    logic sel0 = 1'b1, en0 = 1'b1, ign0 = 1'b0;
    logic sel1 = 1'b1, en1 = 1'b1, ign1 = 1'b0;
    logic clk_lo;
    logic clk_hi;

    int tests = 0;
    int fails = 0;
    int pulses = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit runt_on = 1'b0;
    realtime runt_from = 0.0;
    realtime lo_last = 0.0;
    realtime hi_last = 0.0;

    always #4.0 tb_clk = ~tb_clk;          // 125 MHz bench clock
    always #4.0 clk0   = ~clk0;            // input clock 0, half period 4.0
    initial begin
        #1.3;
        forever #6.7 clk1 = ~clk1;         // input clock 1, half period 6.7
    end

    clk_glitchless_mux #(.PARK_HIGH(1'b0), .PRESELECT(0)) u_dut (
        .clk0_i(clk0), .clk1_i(clk1), .rst_ni(rst_n),
        .sel0_i(sel0), .en0_i(en0), .ign0_i(ign0),
        .sel1_i(sel1), .en1_i(en1), .ign1_i(ign1),
        .clk_o(clk_lo)
    );

    clk_glitchless_mux #(.PARK_HIGH(1'b1), .PRESELECT(1)) u_dut_hi (
        .clk0_i(clk0), .clk1_i(clk1), .rst_ni(rst_n),
        .sel0_i(sel0), .en0_i(en0), .ign0_i(ign0),
        .sel1_i(sel1), .en1_i(en1), .ign1_i(ign1),
        .clk_o(clk_hi)
    );

    task automatic check(string tag, int act, int exp, string what);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int exp_src(logic s0, logic e0, logic s1, logic e1);
        logic r0 = s0 & e0;
        logic r1 = s1 & e1;
        if (r0 && !r1) return 0;
        if (r1 && !r0) return 1;
        return 2;
    endfunction

    function automatic logic exp_level(bit idle_hi, int src, logic c0, logic c1);
        if (src == 0) return c0;
        if (src == 1) return c1;
        return idle_hi;
    endfunction

    // R10: pulse-width monitor for both instances
    always @(clk_lo) begin
        if (runt_on && lo_last >= runt_from) begin
            if (($realtime - lo_last) < 3.99) begin
                tests++; fails++;
                $display("FAIL R10 low-idle pulse: actual %0t expected >= 4.0ns", $realtime - lo_last);
            end else pulses++;
        end
        lo_last = $realtime;
    end
    always @(clk_hi) begin
        if (runt_on && hi_last >= runt_from) begin
            if (($realtime - hi_last) < 3.99) begin
                tests++; fails++;
                $display("FAIL R10 high-idle pulse: actual %0t expected >= 4.0ns", $realtime - hi_last);
            end else pulses++;
        end
        hi_last = $realtime;
    end

    // Compare both outputs with the expected source at eight off-edge points.
    task automatic track(string tag);
        int src = exp_src(sel0, en0, sel1, en1);
        int bad_lo = 0;
        int bad_hi = 0;
        for (int k = 0; k < 8; k++) begin
            #1.3;
            if (clk_lo !== exp_level(1'b0, src, clk0, clk1)) bad_lo++;
            if (clk_hi !== exp_level(1'b1, src, clk0, clk1)) bad_hi++;
        end
        check(tag, bad_lo, 0, "low-idle mismatches");
        check(tag, bad_hi, 0, "high-idle mismatches");
    endtask

    // Drive away from any clock edge, then wait three slow periods (R8).
    task automatic apply(logic a, logic b, logic c, logic d);
        @(posedge tb_clk);
        #0.05;
        sel0 = a; en0 = b; sel1 = c; en1 = d;
        #40.2;
    endtask

    initial begin
        int bad;
        void'($urandom(32'h5eed));

        // R5: during reset, preselected inputs drive the outputs
        #20.05;
        bad = 0;
        for (int k = 0; k < 8; k++) begin
            #1.3;
            if (clk_lo !== clk0) bad++;
            if (clk_hi !== clk1) bad++;
        end
        check("R5", bad, 0, "preselect mismatches during reset");
        @(posedge tb_clk);
        #0.05;
        rst_n = 1'b1;
        #40.2;

        track("R9 both requested parks");
        apply(1'b0, 1'b1, 1'b0, 1'b1);
        track("R6 nothing requested idles");
        apply(1'b1, 1'b0, 1'b0, 1'b1);
        track("R1 select without enable");
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        track("R8 first handover");

        runt_on = 1'b1;
        runt_from = $realtime;
        for (int it = 0; it < 30; it++) begin
            repeat ($urandom_range(0, 3)) @(posedge tb_clk);
            apply(1'($urandom_range(0, 1)), 1'b1, 1'($urandom_range(0, 1)), 1'b1);
            track("R8 random select");
        end

        // R2: switch while clock 0 is high; output must wait for its fall
        apply(1'b1, 1'b1, 1'b0, 1'b1);
        @(posedge clk0);
        #1.05;
        sel0 = 1'b0; sel1 = 1'b1;
        #0.02;
        check("R2", int'(clk_lo), 1, "still on old clock before its fall");
        @(negedge clk0);
        #0.05;
        check("R2", int'(clk_lo), 0, "parked after old falling edge");
        #40.2;
        @(posedge tb_clk);
        #0.05;
        track("R2 on new clock");

        // R3: high-idle instance leaves clock 1 on its rise, holds high
        @(negedge clk1);
        #1.05;
        sel0 = 1'b1; sel1 = 1'b0;
        #0.02;
        check("R3", int'(clk_hi), 0, "still on old clock in its low phase");
        @(posedge clk1);
        @(negedge clk1);
        #0.05;
        check("R3", int'(clk_hi), 1, "held high after old rising edge");
        #40.2;
        @(posedge tb_clk);
        #0.05;
        track("R3 on new clock");

        runt_on = 1'b0;

        // R4: override cuts the high phase short
        @(posedge tb_clk);
        #0.05;
        ign0 = 1'b1;
        #40.2;
        track("R4 override alone has no effect");
        @(posedge clk0);
        #1.05;
        sel0 = 1'b0; sel1 = 1'b1;
        #0.02;
        check("R4", int'(clk0), 1, "clock 0 still high");
        check("R4", int'(clk_lo), 0, "left clock 0 at once");
        #40.2;
        @(posedge tb_clk);
        #0.05;
        track("R4 on new clock");
        ign0 = 1'b0;

        // R7: enable-only switching with both selects high
        apply(1'b1, 1'b1, 1'b1, 1'b0);
        track("R7 enable-only start");
        @(posedge clk0);
        #1.05;
        en0 = 1'b0; en1 = 1'b1;
        #0.02;
        check("R7", int'(clk_lo), 0, "left clock 0 at once");
        #40.2;
        @(posedge tb_clk);
        #0.05;
        track("R7 on new clock");

        check("R10", int'(pulses > 20), 1, "pulses judged by monitor");

        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    always @(posedge tb_clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            done = 1'b1;
            tests++; fails++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule